// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

A flash device model written as synthesizable logic. It holds a small byte-organised storage array that is split into sectors of equal size. A synchronous 16-bit bus port gives it a byte address, write data, read data, a write strobe and a read strobe. Each bus write is read as one step of a command sequence. That sequence covers word program, sector erase with a confirm, clearing and reading the status register, lock and unlock, a buffered multi-word write with a word count and a confirm, and a query mode that returns an identification table.

The command currently pending decides what a read returns: array contents, the 8-bit status register (zero-extended), or one query-table byte. Words are stored little-endian, so the even byte address holds bits 7:0. Address bit 0 is ignored for word accesses. Program and erase complete at once: bit 7 of the status register (ready) is set in the same cycle as the operation.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset every array byte is 0xFF, the status register is 0x00, the device is in read-array mode and rdata_o is 0x0000.
- R2: Writing 0x10 or 0x40 and then a data write stores that data at the second write's word address, with the low byte at the even address. It sets status bit 7, and the device goes back to accepting commands with reads returning array data.
- R3: Writing 0x20 and then 0xD0 sets every byte of the sector that holds the confirm write's address (sector = byte address / sector size) to 0xFF. Other sectors are left unchanged and status bit 7 is set. Reads then return {8'h00, status} until a 0xFF command is written.
- R4: A second erase cycle that is not 0xD0 (0xFF included) erases nothing and returns the device to read-array mode.
- R5: After command 0x70, reads return {8'h00, status}.
- R6: Command 0x50 writes 0x00 to the status register and returns the device to read-array mode.
- R7: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7, and reads then return status. Any other second value returns the device to read-array mode and leaves status unchanged.
- R8: After 0xE8, the next write loads a count N from its low byte. The next N+1 writes each store a word (as in R2) and set status bit 7. A following 0xD0 ends the sequence. Reads return status throughout and after the sequence.
- R9: After 0x98, a read at byte address A returns {8'h00, table[A>>1]}. Entries 0x10..0x12 are 0x51, 0x52, 0x59; entry 0x27 is log2 of the array size in bytes; entry 0x2D is the sector count minus one; every index at or above 0x31 reads 0. A write of 0xFF leaves query mode; any other write stays in it.
- R10: A first-cycle code other than 0x00, 0x10, 0x20, 0x40, 0x50, 0x60, 0x70, 0x98, 0xE8 or 0xFF changes no array byte and leaves the device in read-array mode.
- R11: rdata_o takes its new value on the clock edge that samples re_i high, and it holds its value while re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 16 | Write data; low byte carries command codes |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe, never high together with we_i |
| rdata_o | output | 16 | Registered read data |

## Verification
The bench programs every word of the array, alternating both program codes, and reads the whole array back after each erase, abort and rejected code. A design that decoded the sector from the wrong address bits, or that erased on an aborted second cycle, would corrupt words the model still holds. The buffered write is checked on the exact word count: a design that counted N instead of N+1 words would take the last data word as the confirm. Query reads sweep the indices beyond the table end, and status reads follow both lock completion codes and a rejected lock value, so a mis-routed read mux shows up as array data where status is due.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ARG, PH_DATA, PH_CONFIRM} phase_e;

  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_BUFFER   = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;

  localparam int READY_BIT = 7;
  localparam int QRY_LEN   = 8'h31;

  function automatic logic reads_status(input logic [7:0] c);
    return (c == OP_ERASE) || (c == OP_CLEAR) || (c == OP_LOCK) ||
           (c == OP_STATUS) || (c == OP_BUFFER);
  endfunction
endpackage

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int SECTOR_BYTES = 32,
  parameter int NUM_SECTORS  = 4,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              erase_en_i,
  input  logic [ADDR_W-1:0] erase_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o
);
  localparam int TOTAL  = SECTOR_BYTES * NUM_SECTORS;
  localparam int SECT_W = $clog2(SECTOR_BYTES);
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic [TOTAL*8-1:0]  mem_flat;
  logic [SIDX_W-1:0]   erase_sect;
  logic [ADDR_W-2:0]   wr_word;
  logic [ADDR_W-1:0]   erase_base;
  logic [ADDR_W-1:0]   wr_lo;

  assign erase_sect = erase_addr_i[ADDR_W-1:SECT_W];
  assign erase_base = {erase_sect, {SECT_W{1'b0}}};
  assign wr_word    = wr_addr_i[ADDR_W-1:1];
  assign wr_lo      = {wr_word, 1'b0};

  for (genvar b = 0; b < TOTAL; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= 8'hFF;
      else if (erase_en_i && erase_sect == SIDX_W'(b / SECTOR_BYTES)) byte_q <= 8'hFF;
      else if (wr_en_i && wr_word == (ADDR_W-1)'(b / 2))
        byte_q <= (b % 2 == 1) ? wr_data_i[15:8] : wr_data_i[7:0];
    end
    assign mem_flat[b*8 +: 8] = byte_q;
  end

  assign rd_data_o = {mem_flat[{rd_addr_i[ADDR_W-1:1], 1'b1}*8 +: 8],
                      mem_flat[{rd_addr_i[ADDR_W-1:1], 1'b0}*8 +: 8]};

  assert_erase_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> mem_flat[$past(erase_base)*8 +: 8] == 8'hFF);

  assert_prog_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_flat[$past(wr_lo)*8 +: 8] == $past(wr_data_i[7:0]));
endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom
  import nor_flash_pkg::*;
#(
  parameter int SECTOR_BYTES = 32,
  parameter int NUM_SECTORS  = 4,
  parameter int IDX_W        = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam int TOTAL   = SECTOR_BYTES * NUM_SECTORS;
  localparam int LOG_TOT = $clog2(TOTAL);
  localparam int NS_M1   = NUM_SECTORS - 1;

  logic [31:0] idx_w;
  assign idx_w = 32'(idx_i);

  always_comb begin
    byte_o = 8'h00;
    if (idx_w < QRY_LEN) begin
      unique case (idx_w)
        32'h10: byte_o = 8'h51;
        32'h11: byte_o = 8'h52;
        32'h12: byte_o = 8'h59;
        32'h13: byte_o = 8'h01;
        32'h27: byte_o = 8'(LOG_TOT);
        32'h28: byte_o = 8'h01;
        32'h2C: byte_o = 8'h01;
        32'h2D: byte_o = 8'(NS_M1);
        32'h2E: byte_o = 8'(NS_M1 >> 8);
        32'h2F: byte_o = 8'(SECTOR_BYTES >> 8);
        32'h30: byte_o = 8'(SECTOR_BYTES >> 16);
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       code_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             prog_en_o,
  output logic             erase_en_o,
  output logic [7:0]       cmd_o,
  output logic [7:0]       status_o
);
  phase_e           ph_q, ph_d;
  logic [7:0]       cmd_q, cmd_d, st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             known;

  assign known = code_i inside {OP_NOP, OP_ARRAY, OP_PROG_A, OP_PROG_B, OP_ERASE,
                                OP_CLEAR, OP_LOCK, OP_STATUS, OP_QUERY, OP_BUFFER};

  always_comb begin
    ph_d = ph_q; cmd_d = cmd_q; st_d = st_q; cnt_d = cnt_q;
    prog_en_o = 1'b0; erase_en_o = 1'b0;
    if (we_i) begin
      unique case (ph_q)
        PH_IDLE: begin
          unique case (code_i)
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY, OP_BUFFER: begin
              cmd_d = code_i; ph_d = PH_ARG;
            end
            OP_STATUS: cmd_d = code_i;
            OP_CLEAR: begin st_d = 8'h00; cmd_d = OP_NOP; end
            default: cmd_d = OP_NOP;
          endcase
        end
        PH_ARG: begin
          ph_d = PH_IDLE;
          unique case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin prog_en_o = 1'b1; st_d[READY_BIT] = 1'b1; end
            OP_ERASE:
              if (code_i == OP_CONFIRM) begin erase_en_o = 1'b1; st_d[READY_BIT] = 1'b1; end
              else cmd_d = OP_NOP;
            OP_LOCK:
              if (code_i == OP_CONFIRM || code_i == OP_LOCK_ALT) st_d[READY_BIT] = 1'b1;
              else cmd_d = OP_NOP;
            OP_BUFFER: begin cnt_d = count_i; ph_d = PH_DATA; end
            OP_QUERY:
              if (code_i == OP_ARRAY) cmd_d = OP_NOP;
              else ph_d = PH_ARG;
            default: cmd_d = OP_NOP;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == OP_BUFFER) begin
            prog_en_o = 1'b1;
            st_d[READY_BIT] = 1'b1;
            if (cnt_q == '0) ph_d = PH_CONFIRM;
            else cnt_d = cnt_q - 1'b1;
          end else begin
            cmd_d = OP_NOP; ph_d = PH_IDLE;
          end
        end
        default: begin
          ph_d = PH_IDLE;
          if (cmd_q == OP_BUFFER && code_i == OP_CONFIRM) st_d[READY_BIT] = 1'b1;
          else cmd_d = OP_NOP;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; cmd_q <= OP_NOP; st_q <= 8'h00; cnt_q <= '0;
    end else begin
      ph_q <= ph_d; cmd_q <= cmd_d; st_q <= st_d; cnt_q <= cnt_d;
    end
  end

  assign cmd_o    = cmd_q;
  assign status_o = st_q;

  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ph_q == PH_IDLE && code_i == OP_CLEAR) |=> (st_q == 8'h00 && cmd_q == OP_NOP));

  assert_prog_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ph_q == PH_ARG && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
    |=> (ph_q == PH_IDLE && st_q[READY_BIT]));

  assert_bad_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ph_q == PH_IDLE && !known) |=> (cmd_q == OP_NOP && ph_q == PH_IDLE));

  assert_data_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DATA || ph_q == PH_CONFIRM) |-> cmd_q == OP_BUFFER);

  assert_query_stay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ph_q == PH_ARG && cmd_q == OP_QUERY && code_i != OP_ARRAY) |=> cmd_q == OP_QUERY);

  assert_erase_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_o |-> (ph_q == PH_ARG && code_i == OP_CONFIRM));
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int SECTOR_BYTES = 32,
  parameter int NUM_SECTORS  = 4,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS),
  parameter int CNT_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [15:0]       rdata_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic        prog_en, erase_en;
  logic [7:0]  cmd, status, qry_byte;
  logic [15:0] arr_word;

  nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .we_i,
    .code_i    (wdata_i[7:0]),
    .count_i   (wdata_i[CNT_W-1:0]),
    .prog_en_o (prog_en),
    .erase_en_o(erase_en),
    .cmd_o     (cmd),
    .status_o  (status)
  );

  nor_byte_array #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS), .ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i     (prog_en),
    .wr_addr_i   (addr_i),
    .wr_data_i   (wdata_i),
    .erase_en_i  (erase_en),
    .erase_addr_i(addr_i),
    .rd_addr_i   (addr_i),
    .rd_data_o   (arr_word)
  );

  nor_query_rom #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_qry (
    .idx_i (addr_i[ADDR_W-1:1]),
    .byte_o(qry_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= 16'h0000;
    else if (re_i) begin
      if (reads_status(cmd))    rdata_o <= {8'h00, status};
      else if (cmd == OP_QUERY) rdata_o <= {8'h00, qry_byte};
      else                      rdata_o <= arr_word;
    end
  end

  assert_read_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: tb/nor_cmd_flash_tb_top.sv
module nor_cmd_flash_tb_top;
  localparam int SB = 32;
  localparam int NS = 4;
  localparam int TOT = SB * NS;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [15:0] rdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] em [TOT];

  always #5 clk = ~clk;

  nor_cmd_flash #(.SECTOR_BYTES(SB), .NUM_SECTORS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = AW'(a); re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic logic [15:0] mword(input int a);
    int e = a & ~1;
    return {em[e+1], em[e]};
  endfunction

  task automatic mprog(input int a, input logic [15:0] d);
    em[a & ~1] = d[7:0]; em[(a & ~1) + 1] = d[15:8];
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    int errs = 0;
    for (int w = 0; w < TOT; w += 2) begin
      rd(w, v);
      if (v !== mword(w)) begin
        errs++;
        if (errs == 1) chk(req, v, mword(w));
      end
    end
    if (errs == 0) chk(req, 16'h0, 16'h0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, held;
    for (int i = 0; i < TOT; i++) em[i] = 8'hFF;
    #1 chk("R1 rdata in reset", rdata, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata after reset", rdata, 16'h0000);
    check_all("R1 array erased at reset");
    wr(0, 16'h0070); rd(0, v); chk("R1/R5 status at reset", v, 16'h0000);
    wr(0, 16'h00FF);

    // R2: program every word, alternating both codes
    for (int w = 0; w < TOT; w += 2) begin
      logic [15:0] d = 16'((w * 16'h0403) ^ 16'hA5C3);
      wr(w, (w % 4 == 0) ? 16'h0010 : 16'h0040);
      wr(w + (w % 3 == 0 ? 1 : 0), d);
      mprog(w, d);
    end
    check_all("R2 program sweep readback");
    wr(0, 16'h0070); rd(6, v); chk("R5 status ready after program", v, 16'h0080);
    wr(0, 16'h0050); rd(6, v); chk("R6 read array after clear", v, mword(6));
    wr(0, 16'h0070); rd(6, v); chk("R6 status zero after clear", v, 16'h0000);
    wr(0, 16'h00FF);

    // R3: erase sector 2 via confirm address inside it
    wr(10, 16'h0020); wr(16'h4A, 16'h00D0);
    for (int i = 2 * SB; i < 3 * SB; i++) em[i] = 8'hFF;
    rd(2, v); chk("R3 status after erase", v, 16'h0080);
    wr(0, 16'h00FF);
    check_all("R3 only addressed sector erased");

    // R4: abort paths
    wr(16'h22, 16'h0020); wr(16'h22, 16'h0033);
    rd(16'h22, v); chk("R4 bad confirm returns array", v, mword(16'h22));
    wr(16'h22, 16'h0020); wr(16'h22, 16'h00FF);
    check_all("R4 no erase after abort");

    // R7: lock sequences
    wr(0, 16'h0050);
    wr(0, 16'h0060); wr(0, 16'h0001);
    rd(4, v); chk("R7 lock 0x01 status", v, 16'h0080);
    wr(0, 16'h0050);
    wr(0, 16'h0060); wr(0, 16'h00D0);
    rd(4, v); chk("R7 lock 0xD0 status", v, 16'h0080);
    wr(0, 16'h0050);
    wr(0, 16'h0060); wr(0, 16'h0077);
    rd(4, v); chk("R7 bad lock value returns array", v, mword(4));
    wr(0, 16'h0070); rd(4, v); chk("R7 status unchanged by bad lock", v, 16'h0000);
    wr(0, 16'h00FF);

    // R8: buffered write of N+1 = 4 words
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    rd(0, v); chk("R8 status during buffer setup", v, 16'h0000);
    wr(0, 16'h0003);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d = 16'hB00F + 16'(k * 16'h0111);
      wr(2 * k, d); mprog(2 * k, d);
      rd(2 * k, v); chk("R8 status during buffer data", v, 16'h0080);
    end
    wr(0, 16'h00D0);
    rd(0, v); chk("R8 status after buffer confirm", v, 16'h0080);
    wr(0, 16'h00FF);
    check_all("R8 buffered words stored, rest intact");

    // R11: latency and hold
    rd(0, held);
    @(negedge clk); addr = AW'(2); re = 1'b1;
    #4 chk("R11 old value before edge", rdata, held);
    @(negedge clk); re = 1'b0;
    chk("R11 new value after edge", rdata, mword(2));
    addr = AW'(6);
    @(negedge clk); @(negedge clk);
    chk("R11 holds while re low", rdata, mword(2));

    // R9: query mode
    wr(0, 16'h0098);
    rd(16'h20, v); chk("R9 Q", v, 16'h0051);
    rd(16'h23, v); chk("R9 R", v, 16'h0052);
    rd(16'h24, v); chk("R9 Y", v, 16'h0059);
    rd(16'h4E, v); chk("R9 size log2", v, 16'(7));
    rd(16'h5A, v); chk("R9 sector count-1", v, 16'(NS - 1));
    for (int ix = 16'h31; ix < 64; ix++) begin
      rd(2 * ix, v); chk("R9 index past table", v, 16'h0000);
    end
    wr(0, 16'h0000);
    rd(16'h20, v); chk("R9 stays in query", v, 16'h0051);
    wr(0, 16'h00FF);
    rd(16'h20, v); chk("R9 left query", v, mword(16'h20));

    // R10: unsupported first codes
    foreach (v[i]) begin end
    for (int c = 0; c < 4; c++) begin
      logic [7:0] code = (c == 0) ? 8'h01 : (c == 1) ? 8'h30 : (c == 2) ? 8'h90 : 8'hD0;
      wr(16'h30, {8'h00, code});
      rd(16'h30, v); chk("R10 unsupported code reads array", v, mword(16'h30));
      wr(16'h30, 16'h1234);
    end
    check_all("R10 no array change");

    finished = 1;
    summary();
    $finish;
  end
endmodule